// File: doc/BRIEF.md
# Single-Vector Interrupt Injection Unit

This block sits between the instruction sequencer of a small 8-bit processor core and its opcode fetch path. It decides whether an external interrupt is taken. The request pin is active low and level sensitive. The block looks at it only on the instruction-boundary strobe, which marks the cycle in which an instruction completes. An enable flag gates acceptance. The flag is set by the enable-interrupts decode and cleared by the disable-interrupts decode.

When a request is accepted, the enable flag drops at once and an injection is armed. On the next opcode fetch cycle, the block replaces the memory byte with a one-byte restart opcode. The core executes that opcode as a push of the program counter followed by a call to address 0x0038. During that fetch, the block also tells the core not to advance the program counter and tells the memory not to perform the read.

The enable decode also arms a one-instruction shadow. A handler can therefore end with "enable; return", and the return completes before a request that is still held low is taken again. The decode flags qualify the instruction that completes, so they are presented in the same cycle as the boundary strobe. All interfaces are plain control and data pins with no handshake. The opcode bus is a combinational multiplexer that the fetch stage samples in the strobe cycle.

Top module: `irq_inject_unit`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the enable flag and the shadow are clear and no injection is armed: `opcode` equals `mem_data`, and `pc_inc_inhibit` and `mem_rd_suppress` are 0.
- R2: While the enable flag is clear, a low `irq_n` at any boundary arms no injection.
- R3: A request is accepted at a boundary (`insn_end`=1) when all of these hold: `irq_n`=0, the enable flag is set, the shadow is clear, and neither `dec_ei` nor `dec_di` is asserted in that cycle. The injection takes place on the first `fetch_stb` cycle after the acceptance.
- R4: In the injected fetch cycle, `opcode` is 8'hFF (the restart to 0x0038), and `pc_inc_inhibit` and `mem_rd_suppress` are 1. This happens for exactly one fetch cycle. In every other cycle, `opcode` equals `mem_data` and both strobes are 0.
- R5: Acceptance clears the enable flag. A request held low afterwards arms nothing until a new enable decode.
- R6: A boundary carrying `dec_ei` sets the enable flag and the shadow, and accepts nothing. The next boundary accepts nothing and clears the shadow. A request can be taken no earlier than the second boundary after the enable.
- R7: A boundary carrying `dec_di` clears the enable flag and the shadow, and a low request at that same boundary is not accepted.
- R8: `irq_n` is looked at only in boundary cycles. A low level that is gone by the boundary arms nothing.
- R9: If `irq_n` stays low through a handler ending in enable followed by return, the request is accepted at the boundary of the first instruction after the return, and the next fetch is injected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Active-low level interrupt request, synchronous to clk |
| insn_end | input | 1 | Instruction-boundary strobe, one cycle per instruction |
| fetch_stb | input | 1 | Opcode fetch cycle strobe |
| dec_ei | input | 1 | Completing instruction is enable-interrupts (valid with insn_end) |
| dec_di | input | 1 | Completing instruction is disable-interrupts (valid with insn_end) |
| mem_data | input | 8 | Byte read from memory on the fetch path |
| opcode | output | 8 | Opcode delivered to the core |
| pc_inc_inhibit | output | 1 | Do not advance the program counter in this fetch |
| mem_rd_suppress | output | 1 | Do not perform the memory read in this fetch |

## Verification
The hardest situation to reach is a request that stays low across a whole handler. In that case the only thing that holds off re-entry is the shadow left by the enable decode, one boundary later. The stimulus keeps `irq_n` low from the first acceptance through an enable instruction and a return, then counts injected fetches per phase. This pins re-entry to exactly the boundary after the return. A separate phase enables with the request already low and then releases it before the second boundary. It also issues a disable alongside a low request, to show that both the shadow and the immediate disable block acceptance.

// File: rtl/irq_inj_pkg.sv
package irq_inj_pkg;
  localparam int unsigned OP_W = 8;
  // restart opcode whose effect is "push PC; call 0x0038"
  localparam logic [OP_W-1:0] RESTART_OP = 8'hFF;
endpackage

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic dec_ei,
  input  logic dec_di,
  input  logic take,
  output logic ie_q,
  output logic shadow_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q     <= 1'b0;
      shadow_q <= 1'b0;
    end else if (boundary) begin
      if (dec_di) begin
        ie_q     <= 1'b0;
        shadow_q <= 1'b0;
      end else if (dec_ei) begin
        ie_q     <= 1'b1;
        shadow_q <= 1'b1;
      end else begin
        shadow_q <= 1'b0;
        if (take) ie_q <= 1'b0;
      end
    end
  end

  // R6
  shadow_implies_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_q |-> ie_q);

  // R7
  di_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && dec_di) |=> (!ie_q && !shadow_q));
endmodule

// File: rtl/irq_accept.sv
module irq_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic irq_n,
  input  logic ie,
  input  logic shadow,
  input  logic dec_ei,
  input  logic dec_di,
  input  logic fetch_stb,
  output logic take,
  output logic pending_q
);
  assign take = boundary && !irq_n && ie && !shadow
                && !dec_ei && !dec_di && !pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              pending_q <= 1'b0;
    else if (take)           pending_q <= 1'b1;
    else if (fetch_stb)      pending_q <= 1'b0;
  end

  // R5
  take_drops_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ie);

  // R2
  arm_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending_q) |-> $past(ie));
endmodule

// File: rtl/irq_fetch_mux.sv
module irq_fetch_mux #(
  parameter int unsigned OP_W = irq_inj_pkg::OP_W,
  parameter logic [OP_W-1:0] INJ_OP = irq_inj_pkg::RESTART_OP
) (
  input  logic            fetch_stb,
  input  logic            pending,
  input  logic [OP_W-1:0] mem_data,
  output logic [OP_W-1:0] opcode,
  output logic            inject
);
  assign inject = fetch_stb && pending;

  for (genvar b = 0; b < OP_W; b++) begin : g_bit
    assign opcode[b] = inject ? INJ_OP[b] : mem_data[b];
  end
endmodule

// File: rtl/irq_inject_unit.sv
module irq_inject_unit #(
  parameter int unsigned OP_W = irq_inj_pkg::OP_W,
  parameter logic [OP_W-1:0] INJ_OP = irq_inj_pkg::RESTART_OP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_n,
  input  logic            insn_end,
  input  logic            fetch_stb,
  input  logic            dec_ei,
  input  logic            dec_di,
  input  logic [OP_W-1:0] mem_data,
  output logic [OP_W-1:0] opcode,
  output logic            pc_inc_inhibit,
  output logic            mem_rd_suppress
);
  logic ie, shadow, take, pending, inject;

  irq_enable_ctl u_en (
    .clk(clk), .rst_n(rst_n), .boundary(insn_end),
    .dec_ei(dec_ei), .dec_di(dec_di), .take(take),
    .ie_q(ie), .shadow_q(shadow)
  );

  irq_accept u_acc (
    .clk(clk), .rst_n(rst_n), .boundary(insn_end), .irq_n(irq_n),
    .ie(ie), .shadow(shadow), .dec_ei(dec_ei), .dec_di(dec_di),
    .fetch_stb(fetch_stb), .take(take), .pending_q(pending)
  );

  irq_fetch_mux #(.OP_W(OP_W), .INJ_OP(INJ_OP)) u_mux (
    .fetch_stb(fetch_stb), .pending(pending), .mem_data(mem_data),
    .opcode(opcode), .inject(inject)
  );

  assign pc_inc_inhibit  = inject;
  assign mem_rd_suppress = inject;

  // R4
  single_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc_inhibit |=> !pc_inc_inhibit);

  // R4
  inject_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc_inhibit |-> (fetch_stb && opcode == INJ_OP));
endmodule

// File: tb/irq_inject_unit_tb_top.sv
module irq_inject_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_n = 1'b1, insn_end = 1'b0, fetch_stb = 1'b0;
  logic dec_ei = 1'b0, dec_di = 1'b0;
  logic [7:0] mem_data = 8'h00;
  logic [7:0] opcode;
  logic pc_inc_inhibit, mem_rd_suppress;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_inject_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .insn_end(insn_end),
    .fetch_stb(fetch_stb), .dec_ei(dec_ei), .dec_di(dec_di),
    .mem_data(mem_data), .opcode(opcode),
    .pc_inc_inhibit(pc_inc_inhibit), .mem_rd_suppress(mem_rd_suppress)
  );

  int vectors = 0, errs = 0, inj_seen = 0, op_ctr = 0;
  bit m_ie = 0, m_sh = 0, m_pend = 0, done = 0;
  string tag = "R1";

  task automatic cyc(bit fs, bit be, bit ei, bit di, bit irq_lvl, logic [7:0] md);
    bit exp_inj, old_p, tk;
    logic [7:0] exp_op;
    fetch_stb = fs; insn_end = be; dec_ei = ei; dec_di = di;
    irq_n = irq_lvl; mem_data = md;
    #1;
    exp_inj = fs && m_pend;
    exp_op  = exp_inj ? 8'hFF : md;
    vectors++;
    if (opcode !== exp_op || pc_inc_inhibit !== exp_inj || mem_rd_suppress !== exp_inj) begin
      errs++;
      $display("FAIL %s: opcode=%h inh=%b sup=%b expected opcode=%h inh=%b sup=%b",
               tag, opcode, pc_inc_inhibit, mem_rd_suppress, exp_op, exp_inj, exp_inj);
    end
    if (pc_inc_inhibit === 1'b1) inj_seen++;
    @(posedge clk);
    if (!rst_n) begin
      m_ie = 0; m_sh = 0; m_pend = 0;
    end else begin
      old_p = m_pend;
      tk = 0;
      if (be) begin
        if (di) begin m_ie = 0; m_sh = 0; end
        else if (ei) begin m_ie = 1; m_sh = 1; end
        else begin
          if (!irq_lvl && m_ie && !m_sh && !old_p) begin tk = 1; m_ie = 0; end
          m_sh = 0;
        end
      end
      if (fs && old_p) m_pend = 0;
      if (tk) m_pend = 1;
    end
    @(negedge clk);
  endtask

  // one instruction: fetch, execute, boundary
  task automatic insn(bit ei, bit di, bit irq_mid, bit irq_end);
    op_ctr++;
    cyc(1, 0, 0, 0, irq_mid, 8'(op_ctr * 37 + 5));
    cyc(0, 0, 0, 0, irq_mid, 8'(op_ctr));
    cyc(0, 1, ei, di, irq_end, 8'h00);
  endtask

  task automatic expect_count(int exp);
    vectors++;
    if (inj_seen != exp) begin
      errs++;
      $display("FAIL %s: injected fetches=%0d expected=%0d", tag, inj_seen, exp);
    end
    inj_seen = 0;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state, passthrough
    tag = "R1";
    cyc(1, 0, 0, 0, 0, 8'hA5);
    cyc(1, 1, 1, 0, 0, 8'h3C);
    cyc(1, 0, 0, 0, 0, 8'h5A);
    rst_n = 1'b1;
    cyc(1, 0, 0, 0, 0, 8'hC3);
    expect_count(0);

    // R2: request low while disabled
    tag = "R2";
    repeat (3) insn(0, 0, 0, 0);
    expect_count(0);

    // R8: enable, then low only between boundaries
    tag = "R8";
    insn(1, 0, 1, 1);
    insn(0, 0, 1, 1);
    insn(0, 0, 0, 1);
    insn(0, 0, 0, 1);
    expect_count(0);

    // R3 + R4: accepted at boundary, next fetch injected
    tag = "R3";
    insn(0, 0, 1, 0);
    insn(0, 0, 0, 0);
    expect_count(1);
    // R5: flag cleared, held request ignored
    tag = "R5";
    insn(0, 0, 0, 0);
    insn(0, 0, 0, 0);
    expect_count(0);

    // R9: handler ends enable; return with request still low
    tag = "R9";
    insn(1, 0, 0, 0);
    insn(0, 0, 0, 0);
    expect_count(0);
    insn(0, 0, 0, 0);
    insn(0, 0, 0, 0);
    expect_count(1);

    // R7: disable with request low at the same boundary
    tag = "R7";
    insn(1, 0, 1, 1);
    insn(0, 0, 1, 1);
    insn(0, 1, 0, 0);
    insn(0, 0, 0, 0);
    insn(0, 0, 0, 0);
    expect_count(0);

    // R6: shadow honoured when request goes away before second boundary
    tag = "R6";
    insn(1, 0, 0, 0);
    insn(0, 0, 0, 0);
    insn(0, 0, 1, 1);
    insn(0, 0, 1, 1);
    expect_count(0);
    insn(0, 0, 1, 0);
    insn(0, 0, 1, 1);
    expect_count(1);

    // R4: idle fetches pass memory data
    tag = "R4";
    repeat (4) cyc(1, 0, 0, 0, 1, 8'hFE);
    expect_count(0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule